// File: doc/BRIEF.md
# Control Register File with One-Shot Trigger

This block is a small memory-mapped register file behind an AXI4-Lite slave port. Software reaches three parameter registers and a trigger, and the block drives their values as plain output ports to whatever logic sits beside it. The parameters are a 5-bit mask count, a 32-bit data word and a 32-bit destination address. All three can be written and read back.

The trigger cannot be read and has no storage that software can see. Any completed write to its offset raises the `fire` output for exactly one clock, so downstream logic can use it directly as a start strobe. All five channels use ordinary valid/ready handshakes. The address and data of a write may arrive in either order, and every response is OKAY.

Top module: `pulse_ctrl_regs`

## Requirements
- R1: While `aresetn` is low, every ready and valid output is low and every register output is zero. The ready outputs rise one cycle after reset is released.
- R2: Word offset 1 (byte 0x4) holds the data word and offset 2 (byte 0x8) holds the destination address. Both read back exactly what was written.
- R3: Word offset 0 (byte 0x0) holds a 5-bit mask count taken from write data bits [4:0]. It reads back zero-extended to 32 bits.
- R4: Each completed write to word offset 3 (byte 0xC), whatever its data, raises `fire` for exactly one cycle. This happens in the cycle in which `s_bvalid` rises. Writes to other offsets never raise `fire`.
- R5: A read of word offset 3 returns zero. A write there leaves the three parameter registers unchanged.
- R6: A write takes effect only after both the address and the data handshakes have completed, in either order. `s_bvalid` then rises with `s_bresp` = 2'b00 and stays high until `s_bready`. Both write ready outputs stay low while a response is pending.
- R7: After an address-read handshake, `s_rvalid` rises with `s_rresp` = 2'b00. `s_rdata` holds steady until `s_rready` is seen.
- R8: Strobe bit i enables the write of data byte i (bits 8i+7..8i). A write with all strobes clear changes nothing.
- R9: Only address bits [3:2] select a register. All other address bits are ignored on both reads and writes.
- R10: `mask_count`, `data_word` and `dest_addr` always show the current register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Reset, active low |
| s_awaddr | input | 32 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 32 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| mask_count | output | 5 | Mask count register |
| data_word | output | 32 | Data word register |
| dest_addr | output | 32 | Destination address register |
| fire | output | 1 | One-cycle trigger strobe |

## Verification
The hardest case to reach from the ports is a write whose address and data handshakes are far apart. In that window, nothing may commit, no response may appear and `fire` must stay low. The bench reaches this case in three ways:
- It issues the address alone and then watches the outputs for several cycles before supplying the data.
- It runs writes with the data leading the address.
- It holds `s_bready` and `s_rready` low for several cycles, so the response-hold rules and the single-cycle trigger can be seen while a transaction is stalled.

// File: rtl/pulse_ctrl_regs_pkg.sv
package pulse_ctrl_regs_pkg;
  typedef enum logic [1:0] {
    SLOT_CNT  = 2'd0,
    SLOT_DATA = 2'd1,
    SLOT_DEST = 2'd2,
    SLOT_FIRE = 2'd3
  } slot_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  // Register select uses address bits [3:2] only.
  function automatic slot_e slot_of(input logic [3:0] low_addr);
    return slot_e'(low_addr[3:2]);
  endfunction
endpackage

// File: rtl/pulse_ctrl_regs_wr.sv
module pulse_ctrl_regs_wr
  import pulse_ctrl_regs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              live,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  output logic              commit,
  output slot_e             c_slot,
  output logic [DATA_W-1:0] c_data,
  output logic [STRB_W-1:0] c_strb
);
  logic aw_held, w_held;
  logic unused_awaddr_bits;

  assign unused_awaddr_bits = ^{awaddr[ADDR_W-1:4], awaddr[1:0]};

  assign awready = live && !aw_held && !bvalid;
  assign wready  = live && !w_held && !bvalid;
  assign commit  = aw_held && w_held && !bvalid;
  assign bresp   = RESP_OKAY;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_held <= 1'b0;
      w_held  <= 1'b0;
      bvalid  <= 1'b0;
      c_slot  <= SLOT_CNT;
      c_data  <= '0;
      c_strb  <= '0;
    end else begin
      if (awvalid && awready) begin
        aw_held <= 1'b1;
        c_slot  <= slot_of(awaddr[3:0]);
      end
      if (wvalid && wready) begin
        w_held <= 1'b1;
        c_data <= wdata;
        c_strb <= wstrb;
      end
      if (commit) begin
        aw_held <= 1'b0;
        w_held  <= 1'b0;
        bvalid  <= 1'b1;
      end else if (bvalid && bready) begin
        bvalid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pulse_ctrl_regs_rd.sv
module pulse_ctrl_regs_rd
  import pulse_ctrl_regs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              live,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  output slot_e             rd_slot,
  input  logic [DATA_W-1:0] rd_word
);
  logic unused_araddr_bits;

  assign unused_araddr_bits = ^{araddr[ADDR_W-1:4], araddr[1:0]};
  assign arready = live && !rvalid;
  assign rresp   = RESP_OKAY;
  assign rd_slot = slot_of(araddr[3:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (arvalid && arready) begin
      rvalid <= 1'b1;
      rdata  <= rd_word;
    end else if (rvalid && rready) begin
      rvalid <= 1'b0;
    end
  end
endmodule

// File: rtl/pulse_ctrl_regs_store.sv
module pulse_ctrl_regs_store
  import pulse_ctrl_regs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  slot_e             c_slot,
  input  logic [DATA_W-1:0] c_data,
  input  logic [STRB_W-1:0] c_strb,
  input  slot_e             rd_slot,
  output logic [DATA_W-1:0] rd_word,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] dest_q,
  output logic              fire_q
);
  // Byte-lane merge: strobe i selects new byte i, otherwise old byte kept.
  function automatic logic [DATA_W-1:0] merge_lanes(input logic [DATA_W-1:0] old_w,
                                                    input logic [DATA_W-1:0] new_w,
                                                    input logic [STRB_W-1:0] strb);
    logic [DATA_W-1:0] r;
    r = old_w;
    for (int b = 0; b < STRB_W; b++)
      if (strb[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
    return r;
  endfunction

  logic [DATA_W-1:0] cnt_wide, cnt_merged;
  logic [DATA_W-1:0] unused_cnt_hi;

  assign cnt_wide      = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
  assign cnt_merged    = merge_lanes(cnt_wide, c_data, c_strb);
  assign unused_cnt_hi = cnt_merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      data_q <= '0;
      dest_q <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= commit && (c_slot == SLOT_FIRE);
      if (commit) begin
        case (c_slot)
          SLOT_CNT:  cnt_q  <= cnt_merged[CNT_W-1:0];
          SLOT_DATA: data_q <= merge_lanes(data_q, c_data, c_strb);
          SLOT_DEST: dest_q <= merge_lanes(dest_q, c_data, c_strb);
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    case (rd_slot)
      SLOT_CNT:  rd_word = cnt_wide;
      SLOT_DATA: rd_word = data_q;
      SLOT_DEST: rd_word = dest_q;
      default:   rd_word = '0;
    endcase
  end
endmodule

// File: rtl/pulse_ctrl_regs.sv
module pulse_ctrl_regs
  import pulse_ctrl_regs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              aclk,
  input  logic              aresetn,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [CNT_W-1:0]  mask_count,
  output logic [DATA_W-1:0] data_word,
  output logic [DATA_W-1:0] dest_addr,
  output logic              fire
);
  logic              live;
  logic              commit;
  slot_e             c_slot, rd_slot;
  logic [DATA_W-1:0] c_data, rd_word;
  logic [STRB_W-1:0] c_strb;

  // Ready outputs open one cycle after reset release.
  always_ff @(posedge aclk or negedge aresetn) begin
    if (!aresetn) live <= 1'b0;
    else          live <= 1'b1;
  end

  pulse_ctrl_regs_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(aclk), .rst_n(aresetn), .live(live),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .commit(commit), .c_slot(c_slot), .c_data(c_data), .c_strb(c_strb)
  );

  pulse_ctrl_regs_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(aclk), .rst_n(aresetn), .live(live),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .rd_slot(rd_slot), .rd_word(rd_word)
  );

  pulse_ctrl_regs_store #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_store (
    .clk(aclk), .rst_n(aresetn), .commit(commit), .c_slot(c_slot),
    .c_data(c_data), .c_strb(c_strb), .rd_slot(rd_slot), .rd_word(rd_word),
    .cnt_q(mask_count), .data_q(data_word), .dest_q(dest_addr), .fire_q(fire)
  );
endmodule

// File: rtl/pulse_ctrl_regs_checks.sv
module pulse_ctrl_regs_checks
  import pulse_ctrl_regs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              aclk,
  input logic              aresetn,
  input logic              s_awready,
  input logic              s_wready,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic [ADDR_W-1:0] s_araddr,
  input logic              s_rvalid,
  input logic              s_rready,
  input logic [DATA_W-1:0] s_rdata,
  input logic              fire,
  input logic              commit,
  input slot_e             c_slot
);
  assert_bvalid_hold_R6: assert property (@(posedge aclk) disable iff (!aresetn)
    s_bvalid && !s_bready |=> s_bvalid);

  assert_no_wready_pending_R6: assert property (@(posedge aclk) disable iff (!aresetn)
    s_bvalid |-> !s_awready && !s_wready);

  assert_rdata_hold_R7: assert property (@(posedge aclk) disable iff (!aresetn)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));

  assert_fire_single_R4: assert property (@(posedge aclk) disable iff (!aresetn)
    fire |=> !fire);

  assert_fire_cause_R4: assert property (@(posedge aclk) disable iff (!aresetn)
    fire |-> $past(commit) && $past(c_slot) == SLOT_FIRE);

  assert_fire_with_resp_R4: assert property (@(posedge aclk) disable iff (!aresetn)
    $rose(fire) |-> $rose(s_bvalid));

  assert_trigger_reads_zero_R5: assert property (@(posedge aclk) disable iff (!aresetn)
    $rose(s_rvalid) && $past(s_araddr[3:2]) == 2'd3 |-> s_rdata == '0);
endmodule

bind pulse_ctrl_regs pulse_ctrl_regs_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checks (
  .aclk(aclk), .aresetn(aresetn), .s_awready(s_awready), .s_wready(s_wready),
  .s_bvalid(s_bvalid), .s_bready(s_bready), .s_araddr(s_araddr),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
  .fire(fire), .commit(commit), .c_slot(c_slot)
);

// File: tb/pulse_ctrl_regs_bench.sv
`timescale 1ns/1ps
module pulse_ctrl_regs_bench;
  logic        aclk = 1'b0;
  logic        aresetn = 1'b0;
  logic [31:0] s_awaddr = '0, s_wdata = '0, s_araddr = '0;
  logic [3:0]  s_wstrb = '0;
  logic        s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid, fire;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata, data_word, dest_addr;
  logic [4:0]  mask_count;

  always #2 aclk = ~aclk;

  pulse_ctrl_regs u_pulse_ctrl_regs (.*);

  int checks = 0, failures = 0;
  bit done = 0;

  // Reference model
  logic [31:0] m_cnt = 0, m_data = 0, m_dest = 0;
  int fire_seen = 0, fire_run = 0, fire_expect = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lanes(input logic [31:0] old_w, input logic [31:0] d, input logic [3:0] s);
    logic [31:0] m;
    m = {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
    return (d & m) | (old_w & ~m);
  endfunction

  function automatic logic [31:0] model_read(input logic [31:0] a);
    case (a[3:2])
      2'd0: return m_cnt;
      2'd1: return m_data;
      2'd2: return m_dest;
      default: return 32'h0;
    endcase
  endfunction

  // Pulse monitor: counts pulses, flags any pulse longer than one cycle (R4)
  always @(posedge aclk) begin
    if (fire) begin
      fire_seen++;
      fire_run++;
      if (fire_run > 1) check(0, "R4 pulse width", fire_run, 1);
    end else fire_run = 0;
  end

  // Scoreboard monitor for reads (R2 R3 R5 R7 R9)
  always @(negedge aclk) begin
    #1;
    if (s_rvalid && s_rready) begin
      if (exp_q.size() == 0) check(0, "R7 unexpected read beat", s_rdata, 0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(s_rdata === e, t, s_rdata, e);
        check(s_rresp === 2'b00, "R7 rresp OKAY", s_rresp, 0);
      end
    end
  end

  task automatic send_aw(input logic [31:0] a);
    s_awaddr = a; s_awvalid = 1;
    forever begin
      logic ok;
      ok = s_awready;
      @(posedge aclk);
      if (ok) break;
      @(negedge aclk);
    end
    @(negedge aclk); s_awvalid = 0;
  endtask

  task automatic send_w(input logic [31:0] d, input logic [3:0] s);
    s_wdata = d; s_wstrb = s; s_wvalid = 1;
    forever begin
      logic ok;
      ok = s_wready;
      @(posedge aclk);
      if (ok) break;
      @(negedge aclk);
    end
    @(negedge aclk); s_wvalid = 0;
  endtask

  task automatic finish_b(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s, input int b_lag);
    while (!s_bvalid) @(negedge aclk);
    check(s_bresp === 2'b00, "R6 bresp OKAY", s_bresp, 0);
    if (a[3:2] == 2'd3) begin
      check(fire === 1'b1, "R4 fire with bvalid", fire, 1);
      fire_expect++;
    end
    for (int i = 0; i < b_lag; i++) begin
      @(negedge aclk);
      check(s_bvalid === 1'b1, "R6 bvalid held", s_bvalid, 1);
      check(fire === 1'b0, "R4 fire dropped", fire, 0);
    end
    s_bready = 1; @(posedge aclk); @(negedge aclk); s_bready = 0;
    case (a[3:2])
      2'd0: m_cnt  = {27'd0, lanes(m_cnt, d, s)[4:0]};
      2'd1: m_data = lanes(m_data, d, s);
      2'd2: m_dest = lanes(m_dest, d, s);
      default: ;
    endcase
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s,
                          input int aw_lag, input int w_lag, input int b_lag);
    fork
      begin repeat (aw_lag) @(negedge aclk); send_aw(a); end
      begin repeat (w_lag) @(negedge aclk); send_w(d, s); end
    join
    finish_b(a, d, s, b_lag);
  endtask

  task automatic do_read(input logic [31:0] a, input int r_lag, input string tag);
    s_araddr = a; s_arvalid = 1;
    forever begin
      logic ok;
      ok = s_arready;
      @(posedge aclk);
      if (ok) break;
      @(negedge aclk);
    end
    exp_q.push_back(model_read(a));
    tag_q.push_back(tag);
    @(negedge aclk); s_arvalid = 0;
    while (!s_rvalid) @(negedge aclk);
    for (int i = 0; i < r_lag; i++) begin
      logic [31:0] held;
      held = s_rdata;
      @(negedge aclk);
      check(s_rvalid === 1'b1 && s_rdata === held, "R7 rdata held", s_rdata, held);
    end
    s_rready = 1; @(posedge aclk); @(negedge aclk); s_rready = 0;
  endtask

  task automatic check_outputs(input string req);
    check(mask_count === m_cnt[4:0], {req, " mask_count"}, {27'd0, mask_count}, m_cnt);
    check(data_word === m_data, {req, " data_word"}, data_word, m_data);
    check(dest_addr === m_dest, {req, " dest_addr"}, dest_addr, m_dest);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge aclk);
    check(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge aclk);
    // R1: reset state
    check({s_awready, s_wready, s_arready, s_bvalid, s_rvalid, fire} === 6'b0, "R1 handshake outputs in reset",
          {s_awready, s_wready, s_arready, s_bvalid, s_rvalid, fire}, 0);
    check_outputs("R1");
    aresetn = 1;
    @(negedge aclk);
    @(negedge aclk);
    check({s_awready, s_wready, s_arready} === 3'b111, "R1 ready after reset", {s_awready, s_wready, s_arready}, 3'b111);

    // R3: 5-bit count, zero-extended
    do_write(32'h0, 32'hFFFF_FFE7, 4'hF, 0, 0, 0);
    check_outputs("R3 R10");
    do_read(32'h0, 0, "R3 count readback");

    // R2: data and destination, address first then data first
    do_write(32'h4, 32'h0123_4567, 4'hF, 0, 2, 1);
    do_write(32'h8, 32'hA000_0040, 4'hF, 3, 0, 2);
    check_outputs("R2 R10");
    do_read(32'h4, 0, "R2 data readback");
    do_read(32'h8, 3, "R2 dest readback");

    // R8: partial strobes and empty strobe
    do_write(32'h4, 32'hAABB_CCDD, 4'b0101, 0, 0, 0);
    do_read(32'h4, 0, "R8 partial strobe");
    do_write(32'h8, 32'hFFFF_FFFF, 4'b0000, 0, 0, 0);
    do_read(32'h8, 0, "R8 empty strobe");
    do_write(32'h0, 32'h0000_0013, 4'b1110, 0, 0, 0);
    check_outputs("R8 count strobe");

    // R9: high address bits ignored
    do_write(32'h1234_5008, 32'h5555_AAAA, 4'hF, 0, 0, 0);
    do_read(32'hF0F0_00FB, 0, "R9 aliased read");
    check_outputs("R9");

    // R4 R5: trigger pulses, no side effect, reads zero
    do_write(32'hC, 32'h0, 4'hF, 0, 0, 0);
    check_outputs("R5 after trigger");
    do_write(32'h7000_000C, 32'hFFFF_FFFF, 4'hF, 0, 3, 2);
    do_write(32'hC, 32'h1, 4'h1, 4, 0, 0);
    check_outputs("R5 after trigger");
    do_read(32'hC, 2, "R5 trigger reads zero");

    // R6: address alone does not commit
    begin
      int a_seen;
      a_seen = fire_seen;
      send_aw(32'h4);
      for (int i = 0; i < 4; i++) begin
        @(negedge aclk);
        check(s_bvalid === 1'b0, "R6 no response without data", s_bvalid, 0);
        check(data_word === m_data, "R6 no commit without data", data_word, m_data);
      end
      send_w(32'hDEAD_BEEF, 4'hF);
      finish_b(32'h4, 32'hDEAD_BEEF, 4'hF, 2);
      check(fire_seen == a_seen, "R4 no pulse for data write", fire_seen, a_seen);
    end
    check_outputs("R6 R10");
    do_read(32'h4, 1, "R6 late data readback");

    repeat (4) @(negedge aclk);
    check(fire_seen == fire_expect, "R4 pulse count", fire_seen, fire_expect);
    check(exp_q.size() == 0, "R7 all reads returned", exp_q.size(), 0);
    summary();
  end
endmodule